// File: doc/BRIEF.md
# Gamma Correction Lookup Table with Auto-Indexing Access

This block sits in a video pixel path and remaps each colour component through a 256-entry table before the pixel goes on to the output stage. Each entry holds 24 bits: red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each 8-bit component of the incoming pixel (red in pixIn[23:16], green in pixIn[15:8], blue in pixIn[7:0]) indexes the table on its own, and only that channel's byte of the selected entry is used. A bypass control lets pixels through unchanged, with the same one-step latency.

Software reaches the table through two 32-bit registers that share one port. The index register holds the table position. The entry register reads or writes the table at that position, and every access to it moves the index on by one, so a whole table loads as one index write followed by a burst of entry writes. The table has one port, so a software access to it takes the table away from the pixel path for that cycle, and the pixel output then repeats its previous value for one extra pixel step.

The dot clock and the register clock are one clock. A pixel enable marks the cycles that carry pixels.

Top module: `gamma_palette`

## Requirements
- R1: After reset the index is 0, pixOut is 0, pixOutValid is 0 and regRdValid is 0.
- R2: A write with regWrSel=1 stores regWrData[23:0] in the table at the index. A read with regRdSel=1 returns {8'h00, entry}. A read with regRdSel=0 returns {24'h0, index}.
- R3: Every entry access (a read or a write with select 1) advances the index by one, wrapping from 255 to 0. An index read does not advance it.
- R4: A read returns its data on regRdData with regRdValid high in the cycle after the strobe. An entry read returns the entry at the index in effect before the advance.
- R5: A write with regWrSel=0 loads the index from regWrData[7:0] at once. If an entry access happens in the same cycle, the access uses the old index and the loaded value replaces its advance.
- R6: With gammaBypass=0, a cycle with pixEn=1 and no entry access loads pixOut with the per-channel table lookup of pixIn.
- R7: With gammaBypass=1, a cycle with pixEn=1 loads pixOut with pixIn unchanged, whether or not an entry access happens.
- R8: With gammaBypass=0, a cycle with pixEn=1 and an entry access leaves pixOut at its previous value.
- R9: In a cycle with pixEn=1, pixOutValid takes pixValid. With pixEn=0, pixOut and pixOutValid hold their values.
- R10: An entry write and an entry read in the same cycle use the same index. The read returns the contents from before the write, and the index advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both the register side and the pixel side |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | Write target: 0 index, 1 table entry |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Register read strobe |
| regRdSel | input | 1 | Read target: 0 index, 1 table entry |
| regRdData | output | 32 | Registered read data |
| regRdValid | output | 1 | High in the cycle after a read strobe |
| pixEn | input | 1 | Pixel step enable |
| pixValid | input | 1 | Incoming pixel is valid |
| pixIn | input | 24 | Incoming pixel, red/green/blue |
| gammaBypass | input | 1 | 1 passes pixels unchanged, 0 uses the table |
| pixOut | output | 24 | Corrected pixel |
| pixOutValid | output | 1 | Valid flag aligned with pixOut |

## Verification
The assertions assume that every control input (the strobes, the selects, pixEn and gammaBypass) is 0 or 1 and never unknown once reset is released. They also assume the table was written before any lookup whose result matters. The bench drives all inputs to known values from time zero, fills the whole table before the first lookup, and changes inputs only on falling edges, away from the edge that samples them. The bench reads back only entries it has written itself.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  parameter int CH_W    = 8;
  parameter int N_CH    = 3;
  parameter int ENTRY_W = CH_W * N_CH;
  parameter int IDX_W   = CH_W;
  parameter int DEPTH   = 1 << IDX_W;
  parameter int REG_W   = 32;

  typedef struct packed {
    logic             tblWr;
    logic             tblRd;
    logic             idxRd;
    logic [IDX_W-1:0] idx;
  } palStrobe_t;
endpackage

// File: rtl/gamma_ctrl.sv
module gamma_ctrl
  import gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regWrSel,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             regRdEn,
  input  logic             regRdSel,
  output palStrobe_t       strobe
);
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             entryAccess;
  logic             idxLoad;

  assign idxLoad     = regWrEn && !regWrSel;
  assign entryAccess = (regWrEn && regWrSel) || (regRdEn && regRdSel);

  always_comb begin
    nextIdx = curIdx;
    if (idxLoad)          nextIdx = wrIdx;
    else if (entryAccess) nextIdx = curIdx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curIdx <= '0;
    else       curIdx <= nextIdx;
  end

  always_comb begin
    strobe.tblWr = regWrEn && regWrSel;
    strobe.tblRd = regRdEn && regRdSel;
    strobe.idxRd = regRdEn && !regRdSel;
    strobe.idx   = curIdx;
  end
endmodule

// File: rtl/gamma_dpath.sv
module gamma_dpath
  import gamma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] wrEntry,
  output logic [REG_W-1:0]   regRdData,
  output logic               regRdValid,
  input  logic               pixEn,
  input  logic               pixValid,
  input  logic [ENTRY_W-1:0] pixIn,
  input  logic               gammaBypass,
  output logic [ENTRY_W-1:0] pixOut,
  output logic               pixOutValid
);
  logic [ENTRY_W-1:0] table_q [DEPTH];
  logic [ENTRY_W-1:0] lutOut;
  logic               tableBusy;

  assign tableBusy = strobe.tblWr || strobe.tblRd;

  always_ff @(posedge clk) begin
    if (strobe.tblWr) table_q[strobe.idx] <= wrEntry;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic [ENTRY_W-1:0] sel;
    assign sel = table_q[pixIn[ch*CH_W +: CH_W]];
    assign lutOut[ch*CH_W +: CH_W] = sel[ch*CH_W +: CH_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= strobe.tblRd || strobe.idxRd;
      if (strobe.tblRd)      regRdData <= REG_W'(table_q[strobe.idx]);
      else if (strobe.idxRd) regRdData <= REG_W'(strobe.idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut      <= '0;
      pixOutValid <= 1'b0;
    end else if (pixEn) begin
      pixOutValid <= pixValid;
      if (gammaBypass)     pixOut <= pixIn;
      else if (!tableBusy) pixOut <= lutOut;
    end
  end
endmodule

// File: rtl/gamma_palette.sv
module gamma_palette
  import gamma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regWrSel,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               regRdEn,
  input  logic               regRdSel,
  output logic [REG_W-1:0]   regRdData,
  output logic               regRdValid,
  input  logic               pixEn,
  input  logic               pixValid,
  input  logic [ENTRY_W-1:0] pixIn,
  input  logic               gammaBypass,
  output logic [ENTRY_W-1:0] pixOut,
  output logic               pixOutValid
);
  palStrobe_t strobe;

  gamma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .wrIdx    (regWrData[IDX_W-1:0]),
    .regRdEn  (regRdEn),
    .regRdSel (regRdSel),
    .strobe   (strobe)
  );

  gamma_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrEntry     (regWrData[ENTRY_W-1:0]),
    .regRdData   (regRdData),
    .regRdValid  (regRdValid),
    .pixEn       (pixEn),
    .pixValid    (pixValid),
    .pixIn       (pixIn),
    .gammaBypass (gammaBypass),
    .pixOut      (pixOut),
    .pixOutValid (pixOutValid)
  );
endmodule

// File: rtl/gamma_palette_chk.sv
module gamma_palette_chk
  import gamma_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regWrSel,
  input logic [REG_W-1:0]   regWrData,
  input logic               regRdEn,
  input logic               regRdSel,
  input logic               regRdValid,
  input logic               pixEn,
  input logic               pixValid,
  input logic [ENTRY_W-1:0] pixIn,
  input logic               gammaBypass,
  input logic [ENTRY_W-1:0] pixOut,
  input logic               pixOutValid,
  input logic [IDX_W-1:0]   curIdx
);
  logic acc;
  assign acc = (regWrEn && regWrSel) || (regRdEn && regRdSel);

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !(regWrEn && !regWrSel)) |=> curIdx == $past(curIdx) + IDX_W'(1)); // R3
  AST_IDX_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!acc && !(regWrEn && !regWrSel)) |=> $stable(curIdx)); // R3
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrSel) |=> curIdx == $past(regWrData[IDX_W-1:0])); // R5
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid); // R4
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid); // R4
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && gammaBypass) |=> pixOut == $past(pixIn)); // R7
  AST_HOLD_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && !gammaBypass && acc) |=> $stable(pixOut)); // R8
  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> pixOutValid == $past(pixValid)); // R9
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(pixOut) && $stable(pixOutValid))); // R9
endmodule

bind gamma_palette gamma_palette_chk i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
  .regWrData(regWrData), .regRdEn(regRdEn), .regRdSel(regRdSel),
  .regRdValid(regRdValid), .pixEn(pixEn), .pixValid(pixValid),
  .pixIn(pixIn), .gammaBypass(gammaBypass), .pixOut(pixOut),
  .pixOutValid(pixOutValid), .curIdx(strobe.idx)
);

// File: tb/test_gamma_palette.sv
module test_gamma_palette;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regWrSel = 1'b0, regRdEn = 1'b0, regRdSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic        pixEn = 1'b0, pixValid = 1'b0, gammaBypass = 1'b0;
  logic [23:0] pixIn = '0;
  logic [23:0] pixOut;
  logic        pixOutValid;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;
  logic [23:0] model [256];

  always #10 clk = ~clk;

  gamma_palette i_gamma_palette (.*);

  function automatic logic [23:0] pattern(int i);
    logic [7:0] b = 8'(i);
    return {~b, b ^ 8'h5A, 8'(b * 3)};
  endfunction

  function automatic logic [23:0] lookup(logic [23:0] p);
    logic [23:0] r = model[p[23:16]];
    logic [23:0] g = model[p[15:8]];
    logic [23:0] b = model[p[7:0]];
    return {r[23:16], g[15:8], b[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic sel, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel) begin
      model[i_idx] = d[23:0];
      i_idx++;
    end else i_idx = d[7:0];
  endtask

  logic [7:0] i_idx = '0;

  task automatic regRead(logic sel, output logic [31:0] d, input string req);
    @(negedge clk);
    regRdEn = 1'b1; regRdSel = sel;
    @(negedge clk);
    regRdEn = 1'b0;
    check(req, {31'd0, regRdValid}, 32'd1);
    d = regRdData;
    if (sel) i_idx++;
  endtask

  task automatic pixStep(logic [23:0] p, logic v, logic byp);
    @(negedge clk);
    pixEn = 1'b1; pixIn = p; pixValid = v; gammaBypass = byp;
    @(negedge clk);
    pixEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 pixOut", {8'd0, pixOut}, 32'd0);
    check("R1 pixOutValid", {31'd0, pixOutValid}, 32'd0);
    check("R1 regRdValid", {31'd0, regRdValid}, 32'd0);
    regRead(1'b0, d, "R1");
    check("R1 index", d, 32'd0);
  endtask

  task automatic testFillAndRead();
    logic [31:0] d;
    regWrite(1'b0, 32'd0);
    for (int i = 0; i < 256; i++) regWrite(1'b1, {8'hEE, pattern(i)});
    regRead(1'b0, d, "R3");
    check("R3 wrap to 0", d, 32'd0);
    regWrite(1'b0, 32'd252);
    for (int i = 0; i < 8; i++) begin
      regRead(1'b1, d, "R4");
      check("R2 R4 entry read", d, {8'h00, pattern((252 + i) % 256)});
    end
    regRead(1'b0, d, "R3");
    check("R3 index after wrap", d, 32'd4);
    regRead(1'b0, d, "R3");
    check("R3 index read no advance", d, 32'd4);
  endtask

  task automatic testLookup();
    logic [23:0] pats [4] = '{24'h000000, 24'hFF0180, 24'h12_34_56, 24'hA5_5A_FF};
    for (int i = 0; i < 4; i++) begin
      pixStep(pats[i], 1'b1, 1'b0);
      check("R6 lookup", {8'd0, pixOut}, {8'd0, lookup(pats[i])});
      check("R9 valid", {31'd0, pixOutValid}, 32'd1);
    end
  endtask

  task automatic testBypass();
    pixStep(24'hC0FFEE, 1'b1, 1'b1);
    check("R7 bypass", {8'd0, pixOut}, 32'h00C0FFEE);
    @(negedge clk);
    pixEn = 1'b1; pixIn = 24'h135790; gammaBypass = 1'b1;
    regRdEn = 1'b1; regRdSel = 1'b1;
    @(negedge clk);
    pixEn = 1'b0; regRdEn = 1'b0; i_idx++;
    check("R7 bypass with access", {8'd0, pixOut}, 32'h00135790);
  endtask

  task automatic testHold();
    logic [23:0] prev;
    pixStep(24'h102030, 1'b1, 1'b0);
    prev = lookup(24'h102030);
    check("R6 before hold", {8'd0, pixOut}, {8'd0, prev});
    @(negedge clk);
    pixEn = 1'b1; pixIn = 24'h405060; gammaBypass = 1'b0;
    regRdEn = 1'b1; regRdSel = 1'b1;
    @(negedge clk);
    pixEn = 1'b0; regRdEn = 1'b0; i_idx++;
    check("R8 held on access", {8'd0, pixOut}, {8'd0, prev});
    pixStep(24'h405060, 1'b1, 1'b0);
    check("R8 resumes", {8'd0, pixOut}, {8'd0, lookup(24'h405060)});
  endtask

  task automatic testIndexWins();
    logic [31:0] d;
    regWrite(1'b0, 32'd10);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 1'b0; regWrData = 32'd40;
    regRdEn = 1'b1; regRdSel = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0; i_idx = 8'd40;
    check("R5 read uses old index", regRdData, {8'd0, model[10]});
    regRead(1'b0, d, "R5");
    check("R5 loaded index wins", d, 32'd40);
  endtask

  task automatic testWriteReadSame();
    logic [31:0] d;
    logic [23:0] old;
    regWrite(1'b0, 32'd20);
    old = model[20];
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = 32'h00ABCDEF;
    regRdEn = 1'b1; regRdSel = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    model[20] = 24'hABCDEF; i_idx = 8'd21;
    check("R10 read sees old", regRdData, {8'd0, old});
    regRead(1'b0, d, "R10");
    check("R10 single advance", d, 32'd21);
    regWrite(1'b0, 32'd20);
    regRead(1'b1, d, "R10");
    check("R10 write landed", d, 32'h00ABCDEF);
  endtask

  task automatic testIdle();
    logic [23:0] prev;
    pixStep(24'h0A0B0C, 1'b1, 1'b1);
    prev = pixOut;
    @(negedge clk);
    pixEn = 1'b0; pixIn = 24'h111111; pixValid = 1'b0;
    @(negedge clk);
    check("R9 idle pixOut", {8'd0, pixOut}, {8'd0, prev});
    check("R9 idle valid", {31'd0, pixOutValid}, 32'd1);
    pixStep(24'h222222, 1'b0, 1'b1);
    check("R9 invalid pixel", {31'd0, pixOutValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFillAndRead();
    testLookup();
    testBypass();
    testHold();
    testIndexWins();
    testWriteReadSame();
    testIdle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule